// File: doc/BRIEF.md
# Shared-Cache Event Counter Bank

This block is a bank of eight event counters for the performance monitor of a shared cache, read and written over a simple register bus. Each counter is given an 8-bit event code. The code picks one line out of a 256-wide vector of one-cycle event pulses. A counter advances by one on every clock in which three things hold: its chosen pulse is high, its own enable is set, and the bank-wide run bit is set. The code 0xFF parks a counter so that it never advances.

A counter that rolls over from all ones to zero latches a sticky overflow flag. Software clears these flags by writing ones to a separate clear register. A mask register uses 1 for blocked. The unmasked flags are ORed into one registered interrupt line. A version parameter sets the counter width. Identifiers below 0x30 give 48-bit counters, whose bits 63:48 read as zero and drop writes. Identifiers from 0x30 upward give 64-bit counters. The identifier can be read back at a fixed address.

Top module: `evb_bank`

## Requirements
- R1: Counter n is read and preset as one 64-bit word at address 0x1E00 + 8*n. With a 48-bit version, bits 63:48 always read zero and written values there are dropped.
- R2: Counter n takes its event code from the byte at bits 8*(n mod 4) of the select word at 0x1D00 (n < 4) or 0x1D04 (n >= 4). It advances by one on each clock edge where the pulse line with that index is high.
- R3: A counter whose event code is 0xFF never advances.
- R4: Bit 16 of the control word at 0x0408 is the run bit. While it is 0, no counter advances.
- R5: Bit n of the enable word at 0x1C00 must be 1 for counter n to advance.
- R6: When counter n rolls from its all-ones value to zero, bit n of the status word at 0x0808 is set on that same edge. The bit stays set until it is cleared.
- R7: Writing 1 to bit n at 0x080C clears status bit n, and writing 0 there changes nothing. Writes to 0x0808 are ignored. A rollover on the same edge as a clear leaves the bit set.
- R8: The mask word at 0x0800 blocks counter n's flag when bit n is 1. `irq` equals the OR of status AND NOT mask as it stood one edge earlier.
- R9: The word at 0x1CF0 reads the version identifier and cannot be written.
- R10: A bus write to a counter in the same cycle as an increment loads the written value, and no rollover is flagged.
- R11: After reset, the mask reads 0xFF and every other register and counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| bus_we | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data. 32-bit registers use bits 31:0 |
| bus_rdata | output | 64 | Combinational read data for `bus_addr`. Unmapped addresses read 0 |
| ev_pulse | input | 256 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Registered OR of the unmasked overflow flags |

## Verification
A register write or event pulse that is present before clock edge k shows up in `bus_rdata` right after edge k, because the read path is combinational. An overflow flag that appears at edge k drives `irq` only after edge k+1, because `irq` is registered. The bench changes its inputs on falling edges. At each rising edge it steps a behavioural model, then checks `bus_rdata` and `irq` against that model a quarter period later, so each result is compared in exactly the cycle it is due. The directed steps read registers back one cycle after each write. They check `irq` one cycle after the status or mask change that should move it.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int CODE_W         = 8;
  localparam int CODES_PER_WORD = 4;
  localparam int RUN_BIT        = 16;

  localparam logic [15:0] ADR_CTRL = 16'h0408;
  localparam logic [15:0] ADR_MASK = 16'h0800;
  localparam logic [15:0] ADR_STAT = 16'h0808;
  localparam logic [15:0] ADR_CLR  = 16'h080C;
  localparam logic [15:0] ADR_CEN  = 16'h1C00;
  localparam logic [15:0] ADR_VER  = 16'h1CF0;
  localparam logic [15:0] ADR_SEL  = 16'h1D00;
  localparam logic [15:0] ADR_CNT  = 16'h1E00;

  // identifiers at or above this value carry full 64-bit counters
  localparam logic [31:0] WIDE_FIRST_ID = 32'h0000_0030;

  typedef logic [CODE_W-1:0] evb_code_t;
  localparam evb_code_t CODE_IDLE = '1;

  function automatic int ctr_width(logic [31:0] id);
    return (id >= WIDE_FIRST_ID) ? 64 : 48;
  endfunction
endpackage

// File: rtl/evb_rst_sync.sv
module evb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/evb_ctrl_regs.sv
module evb_ctrl_regs import evb_pkg::*; #(
  parameter int NUM_CTR = 8,
  parameter int NUM_SEL = 2,
  parameter int ADDR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [NUM_CTR-1:0]      wrap,
  output logic                    run,
  output logic [NUM_CTR-1:0]      cen,
  output logic [NUM_CTR-1:0]      mask,
  output logic [NUM_CTR-1:0]      status,
  output logic [NUM_SEL-1:0][31:0] sel_w
);
  logic                    run_q, run_d, run_ld;
  logic [NUM_CTR-1:0]      cen_q, cen_d, cen_ld_v;
  logic [NUM_CTR-1:0]      mask_q, mask_d;
  logic                    cen_ld, mask_ld;
  logic [NUM_CTR-1:0]      stat_q, stat_d, clr_v;
  logic [NUM_SEL-1:0][31:0] sel_q, sel_d;
  logic [NUM_SEL-1:0]      sel_ld;
  logic                    clr_hit;

  always_comb begin
    run_ld  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    cen_ld  = wr_en && (wr_addr == ADDR_W'(ADR_CEN));
    mask_ld = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
    clr_hit = wr_en && (wr_addr == ADDR_W'(ADR_CLR));
    run_d   = wr_data[RUN_BIT];
    cen_d   = wr_data[NUM_CTR-1:0];
    mask_d  = wr_data[NUM_CTR-1:0];
    clr_v   = clr_hit ? wr_data[NUM_CTR-1:0] : '0;
    // a rollover on the same edge wins over the clear
    stat_d  = (stat_q & ~clr_v) | wrap;
    cen_ld_v = cen_d;
  end

  for (genvar w = 0; w < NUM_SEL; w++) begin : g_sel
    localparam logic [15:0] SEL_ADR = ADR_SEL + 16'(4 * w);
    always_comb begin
      sel_ld[w] = wr_en && (wr_addr == ADDR_W'(SEL_ADR));
      sel_d[w]  = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[w] <= '0;
      else if (sel_ld[w]) sel_q[w] <= sel_d[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cen_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (run_ld)  run_q  <= run_d;
      if (cen_ld)  cen_q  <= cen_ld_v;
      if (mask_ld) mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign run    = run_q;
  assign cen    = cen_q;
  assign mask   = mask_q;
  assign status = stat_q;
  assign sel_w  = sel_q;

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((stat_q & $past(wrap)) == $past(wrap))); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
endmodule

// File: rtl/evb_counter.sv
module evb_counter import evb_pkg::*; #(
  parameter int CW      = 48,
  parameter int NUM_EVT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               en,
  input  evb_code_t          code,
  input  logic [NUM_EVT-1:0] ev,
  input  logic               wr_hit,
  input  logic [CW-1:0]      wr_val,
  output logic [CW-1:0]      cnt,
  output logic               wrap
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit, full, cnt_ld;

  always_comb begin
    hit    = run && en && (code != CODE_IDLE) && ev[code];
    full   = (cnt_q == '1);
    wrap   = hit && full && !wr_hit;
    cnt_ld = wr_hit || hit;
    cnt_d  = wr_hit ? wr_val : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_IDLE_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_IDLE && !wr_hit) |=> $stable(cnt_q)); // R3
  AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hit) |=> $stable(cnt_q)); // R4
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_hit) |=> $stable(cnt_q)); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R6
  AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cnt_q == $past(wr_val))); // R10
endmodule

// File: rtl/evb_irq_out.sv
module evb_irq_out #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] status,
  input  logic [NUM_CTR-1:0] mask,
  output logic               irq
);
  logic irq_q, irq_d;

  always_comb irq_d = |(status & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask) == '0) |=> !irq_q); // R8
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask) != '0) |=> irq_q); // R8
endmodule

// File: rtl/evb_bank.sv
module evb_bank import evb_pkg::*; #(
  parameter int          NUM_CTR    = 8,
  parameter logic [31:0] VERSION_ID = 32'h0000_0021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [15:0]  bus_addr,
  input  logic [63:0]  bus_wdata,
  output logic [63:0]  bus_rdata,
  input  logic [255:0] ev_pulse,
  output logic         irq
);
  localparam int ADDR_W  = 16;
  localparam int CW      = ctr_width(VERSION_ID);
  localparam int NUM_EVT = 1 << CODE_W;
  localparam int NUM_SEL = (NUM_CTR + CODES_PER_WORD - 1) / CODES_PER_WORD;

  logic                     rst_s;
  logic                     run;
  logic [NUM_CTR-1:0]       cen, mask, status, wrap;
  logic [NUM_SEL-1:0][31:0] sel_w;
  logic [CW-1:0]            cnt [NUM_CTR];
  logic [63:0]              rd;

  evb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  evb_ctrl_regs #(.NUM_CTR(NUM_CTR), .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata[31:0]), .wrap(wrap), .run(run), .cen(cen),
    .mask(mask), .status(status), .sel_w(sel_w)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int          WORD = i / CODES_PER_WORD;
    localparam int          LSB  = (i % CODES_PER_WORD) * CODE_W;
    localparam logic [15:0] CADR = ADR_CNT + 16'(8 * i);
    logic wr_hit;
    assign wr_hit = bus_we && (bus_addr == CADR);
    evb_counter #(.CW(CW), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk(clk), .rst_n(rst_s), .run(run), .en(cen[i]),
      .code(sel_w[WORD][LSB +: CODE_W]), .ev(ev_pulse),
      .wr_hit(wr_hit), .wr_val(bus_wdata[CW-1:0]),
      .cnt(cnt[i]), .wrap(wrap[i])
    );
  end

  evb_irq_out #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk(clk), .rst_n(rst_s), .status(status), .mask(mask), .irq(irq)
  );

  always_comb begin
    rd = '0;
    if (bus_addr == ADR_CTRL) rd[RUN_BIT] = run;
    if (bus_addr == ADR_MASK) rd[NUM_CTR-1:0] = mask;
    if (bus_addr == ADR_STAT) rd[NUM_CTR-1:0] = status;
    if (bus_addr == ADR_CEN)  rd[NUM_CTR-1:0] = cen;
    if (bus_addr == ADR_VER)  rd[31:0] = VERSION_ID;
    for (int w = 0; w < NUM_SEL; w++)
      if (bus_addr == ADR_SEL + 16'(4 * w)) rd[31:0] = sel_w[w];
    for (int c = 0; c < NUM_CTR; c++)
      if (bus_addr == ADR_CNT + 16'(8 * c)) rd[CW-1:0] = cnt[c];
  end

  assign bus_rdata = rd;

  if (CW < 64) begin : g_narrow
    logic unused_hi;
    assign unused_hi = ^bus_wdata[63:CW];
    AST_UPPER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
      (bus_addr >= ADR_CNT && bus_addr < ADR_CNT + 16'(8 * NUM_CTR))
      |-> (bus_rdata[63:CW] == '0)); // R1
  end

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == ADR_VER) |-> (bus_rdata == 64'(VERSION_ID))); // R9
endmodule

// File: tb/tb_evb_bank.sv
module tb_evb_bank;
  localparam int          CLK_P = 10;
  localparam logic [63:0] CMASK = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [31:0] VER   = 32'h0000_0021;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic [15:0]  bus_addr;
  logic [63:0]  bus_wdata;
  logic [63:0]  bus_rdata;
  logic [255:0] ev_pulse;
  logic         irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";

  evb_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference state
  logic [63:0] m_cnt [8];
  logic        m_run, m_irq;
  logic [7:0]  m_cen, m_mask, m_stat;
  logic [31:0] m_sel [2];
  int          rcnt = 0;

  task automatic model_step();
    logic [7:0]  wrapv, clr, code;
    logic        inc;
    logic [63:0] nc [8];
    wrapv = '0; clr = '0;
    for (int n = 0; n < 8; n++) begin
      code = m_sel[n/4][8*(n%4) +: 8];
      inc  = m_run && m_cen[n] && code != 8'hFF && ev_pulse[code];
      nc[n] = m_cnt[n];
      if (bus_we && bus_addr == 16'h1E00 + 16'(8*n)) nc[n] = bus_wdata & CMASK;
      else if (inc) begin
        if (m_cnt[n] == CMASK) wrapv[n] = 1'b1;
        nc[n] = (m_cnt[n] + 64'd1) & CMASK;
      end
    end
    m_irq = |(m_stat & ~m_mask);
    if (bus_we) begin
      case (bus_addr)
        16'h0408: m_run  = bus_wdata[16];
        16'h0800: m_mask = bus_wdata[7:0];
        16'h080C: clr    = bus_wdata[7:0];
        16'h1C00: m_cen  = bus_wdata[7:0];
        16'h1D00: m_sel[0] = bus_wdata[31:0];
        16'h1D04: m_sel[1] = bus_wdata[31:0];
        default: ;
      endcase
    end
    m_stat = (m_stat & ~clr) | wrapv;
    for (int n = 0; n < 8; n++) m_cnt[n] = nc[n];
  endtask

  task automatic model_reset();
    for (int n = 0; n < 8; n++) m_cnt[n] = '0;
    m_run = 0; m_irq = 0; m_cen = 0; m_mask = 8'hFF; m_stat = 0;
    m_sel[0] = 0; m_sel[1] = 0;
  endtask

  function automatic logic [63:0] model_read(logic [15:0] a);
    logic [63:0] r;
    r = '0;
    case (a)
      16'h0408: r[16]   = m_run;
      16'h0800: r[7:0]  = m_mask;
      16'h0808: r[7:0]  = m_stat;
      16'h1C00: r[7:0]  = m_cen;
      16'h1CF0: r[31:0] = VER;
      16'h1D00: r[31:0] = m_sel[0];
      16'h1D04: r[31:0] = m_sel[1];
      default: ;
    endcase
    for (int n = 0; n < 8; n++) if (a == 16'h1E00 + 16'(8*n)) r = m_cnt[n];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin rcnt = 0; model_reset(); end
    else if (rcnt < 2) begin rcnt++; model_reset(); end
    else model_step();
    #(CLK_P/4);
    checks++;
    if (bus_rdata !== model_read(bus_addr)) begin
      errors++;
      $display("FAIL %s model rdata @%h: actual %h expected %h", cur_req, bus_addr,
               bus_rdata, model_read(bus_addr));
    end
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s model irq: actual %b expected %b", cur_req, irq, m_irq);
    end
  end

  task automatic drive(logic we, logic [15:0] a, logic [63:0] d, logic [255:0] ev);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; ev_pulse = ev;
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d);
    drive(1'b1, a, d, '0);
  endtask

  task automatic pulse(int idx, int n);
    logic [255:0] v;
    v = '0; v[idx] = 1'b1;
    repeat (n) drive(1'b0, 16'h0, '0, v);
  endtask

  task automatic rd_chk(logic [15:0] a, logic [63:0] exp, string tag);
    drive(1'b0, a, '0, '0);
    @(posedge clk); #(CLK_P/4);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read @%h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(logic exp, string tag);
    drive(1'b0, 16'h0, '0, '0);
    @(posedge clk); #(CLK_P/4);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
    end
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; ev_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    cur_req = "R11";
    rd_chk(16'h0800, 64'hFF, "R11");
    rd_chk(16'h0808, 64'h0, "R11");
    rd_chk(16'h0408, 64'h0, "R11");
    rd_chk(16'h1E00, 64'h0, "R11");
    cur_req = "R9";
    rd_chk(16'h1CF0, 64'(VER), "R9");
    wr(16'h1CF0, 64'h55);
    rd_chk(16'h1CF0, 64'(VER), "R9");

    cur_req = "R2";
    wr(16'h1D00, 64'hFF02_0105);
    wr(16'h1D04, 64'h1011_1280);
    wr(16'h1C00, 64'hFF);
    rd_chk(16'h1D04, 64'h1011_1280, "R2");

    cur_req = "R4";
    pulse(5, 3);
    rd_chk(16'h1E00, 64'd0, "R4");
    wr(16'h0408, 64'h1_0000);
    cur_req = "R2";
    pulse(5, 3);
    rd_chk(16'h1E00, 64'd3, "R2");
    pulse(8'h80, 2);
    rd_chk(16'h1E20, 64'd2, "R2");
    cur_req = "R3";
    pulse(255, 4);
    rd_chk(16'h1E18, 64'd0, "R3");

    cur_req = "R5";
    wr(16'h1C00, 64'hFE);
    pulse(5, 2);
    rd_chk(16'h1E00, 64'd3, "R5");
    wr(16'h1C00, 64'hFF);

    cur_req = "R1";
    wr(16'h1E08, 64'hABCD_FFFF_FFFF_FFFE);
    rd_chk(16'h1E08, 64'h0000_FFFF_FFFF_FFFE, "R1");
    cur_req = "R6";
    pulse(1, 2);
    rd_chk(16'h1E08, 64'd0, "R6");
    rd_chk(16'h0808, 64'h02, "R6");
    cur_req = "R8";
    irq_chk(1'b0, "R8");
    wr(16'h0800, 64'hFD);
    irq_chk(1'b1, "R8");

    cur_req = "R7";
    wr(16'h0808, 64'h0);
    rd_chk(16'h0808, 64'h02, "R7");
    wr(16'h080C, 64'h0);
    rd_chk(16'h0808, 64'h02, "R7");
    wr(16'h080C, 64'h02);
    rd_chk(16'h0808, 64'h00, "R7");
    irq_chk(1'b0, "R8");
    wr(16'h1E08, 64'h0000_FFFF_FFFF_FFFF);
    begin
      logic [255:0] v;
      v = '0; v[1] = 1'b1;
      drive(1'b1, 16'h080C, 64'h02, v);
    end
    rd_chk(16'h0808, 64'h02, "R7");
    wr(16'h080C, 64'h02);
    wr(16'h0800, 64'hFF);

    cur_req = "R10";
    begin
      logic [255:0] v;
      v = '0; v[5] = 1'b1;
      drive(1'b1, 16'h1E00, 64'd100, v);
    end
    rd_chk(16'h1E00, 64'd100, "R10");

    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      logic [255:0] v;
      logic [15:0]  a;
      logic [63:0]  d;
      for (int j = 0; j < 8; j++) v[32*j +: 32] = $urandom;
      if ($urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 7))
          0: begin a = 16'h0408; d = ($urandom_range(0, 3) != 0) ? 64'h1_0000 : 64'h0; end
          1: begin a = 16'h0800; d = 64'($urandom_range(0, 255)); end
          2: begin a = 16'h080C; d = 64'($urandom_range(0, 255)); end
          3: begin a = 16'h1C00; d = 64'($urandom_range(0, 255)); end
          4: begin a = 16'h1D00 + 16'(4 * $urandom_range(0, 1)); d = 64'($urandom); end
          5: begin a = 16'h0808; d = 64'($urandom); end
          default: begin
            a = 16'h1E00 + 16'(8 * $urandom_range(0, 7));
            d = {32'($urandom), 32'hFFFF_FFF0 | 32'($urandom_range(0, 15))};
          end
        endcase
        drive(1'b1, a, d, v);
      end else begin
        drive(1'b0, 16'h0800 + 16'(0), '0, v);
        bus_addr = ($urandom_range(0, 1) == 0) ? 16'h0808 : 16'h1E00 + 16'(8 * $urandom_range(0, 7));
      end
    end
    drive(1'b0, 16'h0, '0, '0);
    @(posedge clk); #(CLK_P/2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule